// File: doc/BRIEF.md
# Parity-Protected Memory with Error Capture

The block sits between a CPU bus and a 32-bit word memory whose four bytes each carry one parity bit. On a write it computes even parity for every enabled byte and stores it next to the data. A read returns the word one cycle after the request, and the stored parity is checked at that point. The memory is modelled inside the block as a per-lane RAM whose depth is a parameter. Byte enables let one write touch any subset of lanes.

Software controls the block through a small register window. The status byte sits at offset 0 and the captured failing address sits at offset 4. The first parity error seen while checking is enabled records which lanes failed and the byte address of the read. That record stays frozen until software writes the status byte again. When an error is held and the interrupt is enabled, an interrupt request is raised at the highest priority level. A test bit makes every write store inverted parity, so software can provoke errors on chosen lanes and exercise its error handlers.

Top module: `pmg_guard`

## Requirements
- R1: After reset the status byte reads 0x00, the captured address reads 0, `irq_o` is 0, `irq_lvl_o` is 0 and `mem_rvalid_o` is 0.
- R2: A read request sampled at a clock edge returns the addressed word on `mem_rdata_o`, with `mem_rvalid_o` high, during the following cycle. Only bytes whose `mem_be_i` bit was set on a write are changed, and the data stored under test mode reads back unchanged.
- R3: While status bit 5 (test) is 1, every enabled byte is stored with the inverse of its even parity. A read with checking on then flags every lane written that way.
- R4: Status bits 3..0 are per-lane error flags. Bit 3 covers data bits 31..24, bit 2 covers 23..16, bit 1 covers 15..8 and bit 0 covers 7..0. Bit 7 is 1 whenever any lane flag is 1.
- R5: While status bit 4 (check enable) is 0, reads record no error, even when the stored parity is bad.
- R6: On a captured error, offset 4 reads the full byte address of the failing read request.
- R7: Once an error is held, later errors change neither the lane flags nor the captured address.
- R8: Any write to offset 0 clears the lane flags, the pending bit and the captured address, and loads bits 6, 5 and 4 from the written byte. A write to offset 4 changes nothing.
- R9: `irq_o` is 1 exactly when status bit 6 (interrupt enable) and the pending bit are both 1. `irq_lvl_o` reads 7 while `irq_o` is 1 and 0 otherwise.
- R10: When an error is detected in the same cycle as a write to offset 0, the clear happens first and the new error is then captured.
- R11: Status bits 7 and 3..0 cannot be written. Writing 0xFF reads back as 0x70 with no error held.
- R12: Register offsets other than 0 and 4 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mem_req_i | input | 1 | Memory access request |
| mem_we_i | input | 1 | 1 = write, 0 = read |
| mem_addr_i | input | AW | Byte address (word index taken from bits above 1..0) |
| mem_be_i | input | 4 | Byte write enables, bit i for data byte i |
| mem_wdata_i | input | 32 | Write data |
| mem_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| mem_rvalid_o | output | 1 | Read data valid |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data (status byte) |
| reg_rdata_o | output | AW | Register read data, combinational on `reg_addr_i` |
| irq_o | output | 1 | Error interrupt request |
| irq_lvl_o | output | 3 | Interrupt priority level, 7 while requesting |

## Verification
A table of words drives the main path. Each word is first written with good parity and then has a chosen subset of lanes rewritten under test mode. The subsets are none, each single lane, two non-adjacent lanes and all four, so a swapped or merged lane flag shows up as a wrong mask. The data patterns (all ones, alternating bits, single set bits at the word's ends) separate a parity-sense error from a data-path error. Directed cases then set up two bad words and read them in turn to check the freeze. They also read bad parity with checking off, check the interrupt gate, issue a clear in the very cycle an error arrives, write the read-only bits, and read the unmapped offsets.

// File: rtl/pmg_pkg.sv
package pmg_pkg;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 4;
  localparam int unsigned DW     = LANE_W * LANES;

  localparam logic [2:0] OFF_STATUS = 3'd0;
  localparam logic [2:0] OFF_ADDR   = 3'd4;
  localparam logic [2:0] IRQ_LEVEL  = 3'd7;

  typedef struct packed {
    logic ien;
    logic test;
    logic chk;
  } ctrl_t;

  function automatic logic even_par(input logic [LANE_W-1:0] b);
    return ^b;
  endfunction
endpackage

// File: rtl/pmg_store.sv
module pmg_store
  import pmg_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             we_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             inv_par_i,
  output logic [DW-1:0]    rdata_o,
  output logic [LANES-1:0] rpar_o,
  output logic             rvalid_o,
  output logic [AW-1:0]    raddr_o
);
  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] idx;
  logic             rd_req;
  logic             rvalid_q;
  logic [AW-1:0]    raddr_q;

  assign idx    = addr_i[IDX_W+1:2];
  assign rd_req = req_i && !we_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W:0] ram [DEPTH];
    logic [LANE_W:0] rd_q;
    logic [LANE_W-1:0] wbyte;

    assign wbyte = wdata_i[g*LANE_W +: LANE_W];

    always_ff @(posedge clk_i) begin
      if (req_i && we_i && be_i[g]) begin
        ram[idx] <= {even_par(wbyte) ^ inv_par_i, wbyte};
      end
      if (rd_req) begin
        rd_q <= ram[idx];
      end
    end

    assign rdata_o[g*LANE_W +: LANE_W] = rd_q[LANE_W-1:0];
    assign rpar_o[g]                   = rd_q[LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      raddr_q  <= '0;
    end else begin
      rvalid_q <= rd_req;
      if (rd_req) raddr_q <= addr_i;
    end
  end

  assign rvalid_o = rvalid_q;
  assign raddr_o  = raddr_q;

  // R2
  rd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i) |=> rvalid_o);
  // R2
  no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> !rvalid_o);
endmodule

// File: rtl/pmg_check.sv
module pmg_check
  import pmg_pkg::*;
(
  input  logic [DW-1:0]    rdata_i,
  input  logic [LANES-1:0] rpar_i,
  input  logic             valid_i,
  input  logic             chk_en_i,
  output logic [LANES-1:0] lane_err_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    // stored bit plus byte must hold an even count of ones
    assign lane_err_o[g] = valid_i && chk_en_i &&
                           (even_par(rdata_i[g*LANE_W +: LANE_W]) ^ rpar_i[g]);
  end
endmodule

// File: rtl/pmg_capture.sv
module pmg_capture
  import pmg_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  ctrl_t            ctrl_i,
  input  logic [LANES-1:0] lane_err_i,
  input  logic [AW-1:0]    err_addr_i,
  output ctrl_t            ctrl_o,
  output logic [LANES-1:0] flags_o,
  output logic [AW-1:0]    addr_o,
  output logic             pend_o
);
  ctrl_t            ctrl_q;
  logic [LANES-1:0] flags_q;
  logic [AW-1:0]    addr_q;
  logic             pend_q;
  logic             new_err;
  logic             take;

  assign pend_q  = |flags_q;
  assign new_err = |lane_err_i;
  // clear is applied first, so a same-cycle error still lands
  assign take    = new_err && (!pend_q || clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flags_q <= '0;
      addr_q  <= '0;
    end else begin
      if (clr_i) begin
        ctrl_q  <= ctrl_i;
        flags_q <= '0;
        addr_q  <= '0;
      end
      if (take) begin
        flags_q <= lane_err_i;
        addr_q  <= err_addr_i;
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign flags_o = flags_q;
  assign addr_o  = addr_q;
  assign pend_o  = pend_q;

  // R7
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> ($stable(flags_q) && $stable(addr_q)));
  // R8
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !new_err) |=> (flags_q == '0 && addr_q == '0 && ctrl_q == $past(ctrl_i)));
  // R10
  clr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && new_err) |=> (flags_q == $past(lane_err_i) && addr_q == $past(err_addr_i)));
  // R5
  chk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_q.chk && !pend_q) |=> !pend_q);
endmodule

// File: rtl/pmg_guard.sv
module pmg_guard
  import pmg_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned AW    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mem_req_i,
  input  logic             mem_we_i,
  input  logic [AW-1:0]    mem_addr_i,
  input  logic [LANES-1:0] mem_be_i,
  input  logic [DW-1:0]    mem_wdata_i,
  output logic [DW-1:0]    mem_rdata_o,
  output logic             mem_rvalid_o,
  input  logic             reg_wr_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [7:0]       reg_wdata_i,
  output logic [AW-1:0]    reg_rdata_o,
  output logic             irq_o,
  output logic [2:0]       irq_lvl_o
);
  localparam int unsigned ST_W = 8;

  ctrl_t            ctrl;
  ctrl_t            ctrl_wr;
  logic [LANES-1:0] rpar;
  logic [LANES-1:0] lane_err;
  logic [LANES-1:0] flags;
  logic [AW-1:0]    raddr;
  logic [AW-1:0]    cap_addr;
  logic             pend;
  logic             clr;
  logic [ST_W-1:0]  status;
  logic             unused_wdata;

  assign clr          = reg_wr_i && (reg_addr_i == OFF_STATUS);
  assign ctrl_wr      = '{ien: reg_wdata_i[6], test: reg_wdata_i[5], chk: reg_wdata_i[4]};
  assign unused_wdata = ^{reg_wdata_i[7], reg_wdata_i[3:0]};

  pmg_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (mem_req_i),
    .we_i      (mem_we_i),
    .addr_i    (mem_addr_i),
    .be_i      (mem_be_i),
    .wdata_i   (mem_wdata_i),
    .inv_par_i (ctrl.test),
    .rdata_o   (mem_rdata_o),
    .rpar_o    (rpar),
    .rvalid_o  (mem_rvalid_o),
    .raddr_o   (raddr)
  );

  pmg_check u_check (
    .rdata_i    (mem_rdata_o),
    .rpar_i     (rpar),
    .valid_i    (mem_rvalid_o),
    .chk_en_i   (ctrl.chk),
    .lane_err_o (lane_err)
  );

  pmg_capture #(.AW(AW)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .ctrl_i     (ctrl_wr),
    .lane_err_i (lane_err),
    .err_addr_i (raddr),
    .ctrl_o     (ctrl),
    .flags_o    (flags),
    .addr_o     (cap_addr),
    .pend_o     (pend)
  );

  assign status = {pend, ctrl.ien, ctrl.test, ctrl.chk, flags};

  always_comb begin
    case (reg_addr_i)
      OFF_STATUS: reg_rdata_o = {{(AW-ST_W){1'b0}}, status};
      OFF_ADDR:   reg_rdata_o = cap_addr;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o     = ctrl.ien && pend;
  assign irq_lvl_o = irq_o ? IRQ_LEVEL : 3'd0;

  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> (reg_rdata_o == cap_addr || reg_addr_i != OFF_ADDR) && irq_lvl_o == 3'd7);
endmodule

// File: tb/pmg_guard_tb.sv
`timescale 1ns/1ps
module pmg_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [31:0] addr = '0, wdata = '0;
  logic [3:0]  be = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic        rwr = 1'b0;
  logic [2:0]  raddr = '0;
  logic [7:0]  rwdata = '0;
  logic [31:0] rrdata;
  logic        irq;
  logic [2:0]  irq_lvl;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  pmg_guard u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .mem_req_i(req), .mem_we_i(we), .mem_addr_i(addr), .mem_be_i(be),
    .mem_wdata_i(wdata), .mem_rdata_o(rdata), .mem_rvalid_o(rvalid),
    .reg_wr_i(rwr), .reg_addr_i(raddr), .reg_wdata_i(rwdata), .reg_rdata_o(rrdata),
    .irq_o(irq), .irq_lvl_o(irq_lvl)
  );

  // address, data, lanes to corrupt
  localparam logic [67:0] VECS [8] = '{
    {32'h0000_0000, 32'h1234_5678, 4'h0},
    {32'h0000_0004, 32'hFFFF_FFFF, 4'h0},
    {32'h0000_0008, 32'hA5A5_A5A5, 4'h1},
    {32'h0000_000C, 32'h00FF_00FF, 4'h4},
    {32'h0000_0010, 32'h8000_0001, 4'h8},
    {32'h0000_0014, 32'h0F0F_0F0F, 4'h2},
    {32'h0000_00FC, 32'hDEAD_BEEF, 4'hF},
    {32'h0000_0020, 32'h0000_0000, 4'hA}
  };

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", r, act, exp);
    end
  endtask

  task automatic mem_wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic mem_rd(input logic [31:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0; d = rdata; v = rvalid;
    @(negedge clk);
  endtask

  task automatic reg_wr(input logic [2:0] off, input logic [7:0] v);
    @(negedge clk); rwr = 1'b1; raddr = off; rwdata = v;
    @(negedge clk); rwr = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] off, output logic [31:0] v);
    raddr = off; #1; v = rrdata;
  endtask

  initial begin
    #(8 * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, d;
    logic        vl;

    repeat (3) @(negedge clk);
    reg_rd(3'd0, v); chk("R1 status", v, 32'h0);
    reg_rd(3'd4, v); chk("R1 addr", v, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 lvl", {29'd0, irq_lvl}, 32'd0);
    chk("R1 rvalid", {31'd0, rvalid}, 32'd0);
    rst_n = 1'b1;

    reg_wr(3'd0, 8'h10);
    reg_rd(3'd0, v); chk("R8 load ctrl", v, 32'h10);

    // table walk: R2 R3 R4 R6
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, dd;
      logic [3:0]  m;
      a = VECS[i][67:36]; dd = VECS[i][35:4]; m = VECS[i][3:0];
      reg_wr(3'd0, 8'h10);
      mem_wr(a, dd, 4'hF);
      if (m != 0) begin
        reg_wr(3'd0, 8'h30);
        mem_wr(a, dd, m);
        reg_wr(3'd0, 8'h10);
      end
      mem_rd(a, d, vl);
      chk("R2 rvalid", {31'd0, vl}, 32'd1);
      chk("R2 data", d, dd);
      reg_rd(3'd0, v);
      chk("R4 lane flags", v, {24'd0, (m != 0), 3'b001, m});
      reg_rd(3'd4, v);
      chk("R6 addr", v, (m != 0) ? a : 32'h0);
      chk("R9 irq off", {31'd0, irq}, 32'd0);
    end

    // R3 all lanes inverted
    reg_wr(3'd0, 8'h30);
    mem_wr(32'h40, 32'h0102_0304, 4'hF);
    reg_wr(3'd0, 8'h10);
    mem_rd(32'h40, d, vl);
    chk("R3 data", d, 32'h0102_0304);
    reg_rd(3'd0, v); chk("R3 status", v, 32'h9F);

    // R7 freeze
    reg_wr(3'd0, 8'h10);
    mem_wr(32'h48, 32'h1111_1111, 4'hF);
    mem_wr(32'h4C, 32'h2222_2222, 4'hF);
    reg_wr(3'd0, 8'h30);
    mem_wr(32'h48, 32'h3333_3333, 4'h1);
    mem_wr(32'h4C, 32'h4444_4444, 4'h8);
    reg_wr(3'd0, 8'h10);
    mem_rd(32'h48, d, vl);
    chk("R2 byte enable", d, 32'h1111_1133);
    reg_rd(3'd0, v); chk("R4 lane0", v, 32'h91);
    mem_rd(32'h4C, d, vl);
    chk("R2 byte enable hi", d, 32'h4422_2222);
    reg_rd(3'd0, v); chk("R7 flags frozen", v, 32'h91);
    reg_rd(3'd4, v); chk("R7 addr frozen", v, 32'h48);

    // R5 checking off
    reg_wr(3'd0, 8'h00);
    mem_rd(32'h4C, d, vl);
    reg_rd(3'd0, v); chk("R5 no capture", v, 32'h0);
    reg_rd(3'd4, v); chk("R5 addr", v, 32'h0);

    // R9 interrupt
    reg_wr(3'd0, 8'h50);
    chk("R9 no err no irq", {31'd0, irq}, 32'd0);
    mem_rd(32'h4C, d, vl);
    chk("R9 irq", {31'd0, irq}, 32'd1);
    chk("R9 lvl", {29'd0, irq_lvl}, 32'd7);
    reg_rd(3'd0, v); chk("R9 status", v, 32'hD8);
    reg_wr(3'd0, 8'h40);
    chk("R9 irq cleared", {31'd0, irq}, 32'd0);
    chk("R9 lvl cleared", {29'd0, irq_lvl}, 32'd0);

    // R10 clear and error in the same cycle
    reg_wr(3'd0, 8'h10);
    mem_rd(32'h48, d, vl);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = 32'h4C;
    @(negedge clk); req = 1'b0; rwr = 1'b1; raddr = 3'd0; rwdata = 8'h10;
    @(negedge clk); rwr = 1'b0;
    reg_rd(3'd0, v); chk("R10 status", v, 32'h98);
    reg_rd(3'd4, v); chk("R10 addr", v, 32'h4C);

    // R11 read-only bits
    reg_wr(3'd0, 8'hFF);
    reg_rd(3'd0, v); chk("R11 status", v, 32'h70);
    reg_rd(3'd4, v); chk("R11 addr", v, 32'h0);
    reg_wr(3'd0, 8'h10);

    // R8 offset 4 write ignored
    mem_rd(32'h48, d, vl);
    reg_wr(3'd4, 8'hAB);
    reg_rd(3'd0, v); chk("R8 off4 status", v, 32'h91);
    reg_rd(3'd4, v); chk("R8 off4 addr", v, 32'h48);

    // R12 unmapped offsets
    for (int o = 1; o < 8; o++) begin
      if (o != 4) begin
        reg_rd(o[2:0], v); chk("R12 unmapped", v, 32'h0);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule